// File: doc/BRIEF.md
# Dual-Rail Pipeline Stage Handshake Controller

This block sequences one stage of a return-to-zero asynchronous pipeline whose data travels as dual-rail pairs. Each pair carries either a data token, with exactly one rail high, or the spacer, with both rails low. A completion detector decides whether the stage inputs form a full token or a full spacer. An enable register then grants evaluation power to the stage logic. A phase sequencer walks the stage through wait, evaluate, hold and discharge, and drives the acknowledge that goes back to the stage two positions upstream.

The acknowledge input comes from the stage two positions downstream. In the early-release variant that acknowledge removes the enable at once, even while the inputs still hold a token, so the stage can sleep before the next spacer arrives. In the basic variant the enable acts as a C-element over input-valid and not-acknowledge. A detector variant can judge validity from one known-slowest pair instead of from every pair.

The controller is a synchronous, clocked model of the control sequencing. It is shared by every gate of the stage. The pipeline data flows through the stage logic rather than through this block, so all of its pins are plain control and status signals, and it has no valid/ready stream interface.

Top module: `rz_stage_ctrl`

## Requirements
- R1: While `rst_n` is low, `pwr_en`, `ack_up` and `illegal` are 0 and `phase_o` is 0 (wait).
- R2: In full-detector mode (`DET_MODE`=0), the inputs count as valid only when every pair has exactly one rail high, where a pair is bit k of `rail_t` together with bit k of `rail_f`. They count as empty only when every pair is (0,0).
- R3: Basic variant (`EARLY_REL`=0): one edge after valid inputs meet `ack_dn`=0, `pwr_en` is 1. One edge after non-valid inputs meet `ack_dn`=1, `pwr_en` is 0. In every other case `pwr_en` holds.
- R4: Early-release variant (`EARLY_REL`=1): one edge after `ack_dn`=1, `pwr_en` is 0 whatever the inputs. With `ack_dn`=0, valid inputs set `pwr_en`, and otherwise `pwr_en` holds.
- R5: `phase_o` encodes wait=0, evaluate=1, hold=2 and discharge=3, and it only ever steps in the order 0,1,2,3,0. It leaves wait on the edge after `pwr_en` is seen high, and it leaves evaluate after one cycle.
- R6: `ack_up` is 1 exactly while `phase_o` is hold or discharge.
- R7: Hold moves to discharge on an edge where the inputs are empty. Discharge moves to wait on an edge where the inputs are empty and `pwr_en` is 0.
- R8: One edge after any pair is (1,1), `illegal` is 1. On an edge where no pair is (1,1), it returns to 0.
- R9: Slow-pair mode (`DET_MODE`=1): validity and emptiness are judged from pair `SLOW_IDX` alone.
- R10: In full-detector mode, a partial token (some pairs live and some empty) neither sets `pwr_en` nor moves hold to discharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_t | input | N_PAIRS | True rails of the stage inputs |
| rail_f | input | N_PAIRS | False rails of the stage inputs |
| ack_dn | input | 1 | Acknowledge from the stage two positions downstream |
| pwr_en | output | 1 | Evaluation enable (power grant) for the stage logic |
| ack_up | output | 1 | Acknowledge to the stage two positions upstream |
| phase_o | output | 2 | Current phase: 0 wait, 1 evaluate, 2 hold, 3 discharge |
| illegal | output | 1 | Set when a pair had both rails high on the previous edge |

## Verification
`pwr_en` and `illegal` are due one rising edge after the inputs they depend on. A phase step is due one edge after the `pwr_en` or input condition that triggers it, so a fresh token shows up in `phase_o` as evaluate two edges after it is applied, and `ack_up` follows `phase_o` with no extra delay. The bench drives inputs at the falling edge and advances its own model just after the rising edge. It compares all outputs at the following falling edge, so every check lands one cycle after the stimulus it covers. Three instances (early full-detector, basic full-detector, early slow-pair) see the same directed and random stimulus.

// File: rtl/rzs_pkg.sv
package rzs_pkg;
  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_EVAL  = 2'd1,
    PH_HOLD  = 2'd2,
    PH_DISCH = 2'd3
  } phase_e;

  localparam int DET_FULL = 0;
  localparam int DET_SLOW = 1;
endpackage

// File: rtl/rzs_completion.sv
module rzs_completion #(
  parameter int N_PAIRS  = 4,
  parameter int DET_MODE = 0,
  parameter int SLOW_IDX = 0
) (
  input  logic [N_PAIRS-1:0] rail_t,
  input  logic [N_PAIRS-1:0] rail_f,
  output logic               in_valid,
  output logic               in_empty,
  output logic               in_bad
);
  import rzs_pkg::*;

  logic [N_PAIRS-1:0] bad_pairs;
  assign bad_pairs = rail_t & rail_f;
  assign in_bad    = |bad_pairs;

  generate
    if (DET_MODE == DET_SLOW) begin : g_slow
      logic live_s;
      assign live_s   = rail_t[SLOW_IDX] | rail_f[SLOW_IDX];
      assign in_valid = live_s & ~bad_pairs[SLOW_IDX];
      assign in_empty = ~live_s;
    end else begin : g_full
      logic [N_PAIRS-1:0] live;
      assign live     = rail_t | rail_f;
      assign in_valid = (&live) & ~(|bad_pairs);
      assign in_empty = ~(|live);
    end
  endgenerate
endmodule

// File: rtl/rzs_enable_gate.sv
module rzs_enable_gate #(
  parameter bit EARLY_REL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic ack_dn,
  output logic en_q
);
  logic en_d;

  generate
    if (EARLY_REL) begin : g_early
      always_comb begin
        en_d = en_q;
        if (ack_dn)        en_d = 1'b0;
        else if (in_valid) en_d = 1'b1;
      end
    end else begin : g_basic
      always_comb begin
        en_d = en_q;
        if (in_valid && !ack_dn)      en_d = 1'b1;
        else if (!in_valid && ack_dn) en_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/rzs_phase_seq.sv
module rzs_phase_seq (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            in_empty,
  output rzs_pkg::phase_e phase_q
);
  import rzs_pkg::*;

  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_WAIT:  if (en) phase_d = PH_EVAL;
      PH_EVAL:  phase_d = PH_HOLD;
      PH_HOLD:  if (in_empty) phase_d = PH_DISCH;
      PH_DISCH: if (in_empty && !en) phase_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_WAIT;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/rz_stage_ctrl.sv
module rz_stage_ctrl #(
  parameter int N_PAIRS   = 4,
  parameter bit EARLY_REL = 1'b1,
  parameter int DET_MODE  = 0,
  parameter int SLOW_IDX  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PAIRS-1:0] rail_t,
  input  logic [N_PAIRS-1:0] rail_f,
  input  logic               ack_dn,
  output logic               pwr_en,
  output logic               ack_up,
  output logic [1:0]         phase_o,
  output logic               illegal
);
  import rzs_pkg::*;

  logic   in_valid;
  logic   in_empty;
  logic   in_bad;
  logic   bad_q;
  phase_e phase_q;

  rzs_completion #(
    .N_PAIRS (N_PAIRS),
    .DET_MODE(DET_MODE),
    .SLOW_IDX(SLOW_IDX)
  ) u_cd (
    .rail_t  (rail_t),
    .rail_f  (rail_f),
    .in_valid(in_valid),
    .in_empty(in_empty),
    .in_bad  (in_bad)
  );

  rzs_enable_gate #(
    .EARLY_REL(EARLY_REL)
  ) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .ack_dn  (ack_dn),
    .en_q    (pwr_en)
  );

  rzs_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (pwr_en),
    .in_empty(in_empty),
    .phase_q (phase_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= in_bad;
  end

  assign illegal = bad_q;
  assign phase_o = phase_q;
  assign ack_up  = (phase_q == PH_HOLD) || (phase_q == PH_DISCH);
endmodule

// File: rtl/rzs_checker.sv
module rzs_checker #(
  parameter int N_PAIRS   = 4,
  parameter bit EARLY_REL = 1'b1,
  parameter int DET_MODE  = 0,
  parameter int SLOW_IDX  = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PAIRS-1:0] rail_t,
  input logic [N_PAIRS-1:0] rail_f,
  input logic               ack_dn,
  input logic               pwr_en,
  input logic               ack_up,
  input logic [1:0]         phase_o,
  input logic               illegal
);
  logic vld_c;
  always_comb begin
    if (DET_MODE == 1) vld_c = rail_t[SLOW_IDX] ^ rail_f[SLOW_IDX];
    else               vld_c = &(rail_t ^ rail_f);
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!pwr_en && !ack_up && !illegal && phase_o == 2'd0));

  a_r3_basic_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!EARLY_REL && vld_c && !ack_dn) |=> pwr_en);

  a_r4_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (EARLY_REL && ack_dn) |=> !pwr_en);

  a_r5_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |-> (phase_o == $past(phase_o) + 2'd1));

  a_r6_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_up) |-> (phase_o == 2'd2));

  a_r8_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rail_t & rail_f)) |=> illegal);
endmodule

bind rz_stage_ctrl rzs_checker #(
  .N_PAIRS  (N_PAIRS),
  .EARLY_REL(EARLY_REL),
  .DET_MODE (DET_MODE),
  .SLOW_IDX (SLOW_IDX)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rail_t (rail_t),
  .rail_f (rail_f),
  .ack_dn (ack_dn),
  .pwr_en (pwr_en),
  .ack_up (ack_up),
  .phase_o(phase_o),
  .illegal(illegal)
);

// File: tb/rz_stage_ctrl_tb.sv
module rz_stage_ctrl_tb;
  localparam int N = 4;
  localparam int SLOW = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] rt = '0;
  logic [N-1:0] rf = '0;
  logic         ack = 1'b0;

  logic       en_o  [3];
  logic       ack_o [3];
  logic [1:0] ph_o  [3];
  logic       ill_o [3];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state: 0 early/full, 1 basic/full, 2 early/slow
  logic       m_en [3];
  logic [1:0] m_ph [3];
  logic       m_ill;

  always #10 clk = ~clk;

  rz_stage_ctrl #(.N_PAIRS(N), .EARLY_REL(1'b1), .DET_MODE(0), .SLOW_IDX(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .rail_t(rt), .rail_f(rf), .ack_dn(ack),
    .pwr_en(en_o[0]), .ack_up(ack_o[0]), .phase_o(ph_o[0]), .illegal(ill_o[0]));

  rz_stage_ctrl #(.N_PAIRS(N), .EARLY_REL(1'b0), .DET_MODE(0), .SLOW_IDX(0)) u_basic (
    .clk(clk), .rst_n(rst_n), .rail_t(rt), .rail_f(rf), .ack_dn(ack),
    .pwr_en(en_o[1]), .ack_up(ack_o[1]), .phase_o(ph_o[1]), .illegal(ill_o[1]));

  rz_stage_ctrl #(.N_PAIRS(N), .EARLY_REL(1'b1), .DET_MODE(1), .SLOW_IDX(SLOW)) u_slow (
    .clk(clk), .rst_n(rst_n), .rail_t(rt), .rail_f(rf), .ack_dn(ack),
    .pwr_en(en_o[2]), .ack_up(ack_o[2]), .phase_o(ph_o[2]), .illegal(ill_o[2]));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R2 / R9: validity and emptiness per requirement
  function automatic logic is_valid(input int k, input logic [N-1:0] t, input logic [N-1:0] f);
    if (k == 2) return (t[SLOW] != f[SLOW]);
    for (int i = 0; i < N; i++) if (t[i] == f[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic is_empty(input int k, input logic [N-1:0] t, input logic [N-1:0] f);
    if (k == 2) return !(t[SLOW] || f[SLOW]);
    return ((t | f) == '0);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      m_en[k] = 1'b0;
      m_ph[k] = 2'd0;
    end
    m_ill = 1'b0;
  endtask

  task automatic model_edge();
    for (int k = 0; k < 3; k++) begin
      logic v, e, en_n;
      logic [1:0] ph_n;
      v = is_valid(k, rt, rf);
      e = is_empty(k, rt, rf);
      en_n = m_en[k];
      if (k != 1) begin
        if (ack) en_n = 1'b0;
        else if (v) en_n = 1'b1;
      end else begin
        if (v && !ack) en_n = 1'b1;
        else if (!v && ack) en_n = 1'b0;
      end
      ph_n = m_ph[k];
      case (m_ph[k])
        2'd0: if (m_en[k]) ph_n = 2'd1;
        2'd1: ph_n = 2'd2;
        2'd2: if (e) ph_n = 2'd3;
        2'd3: if (e && !m_en[k]) ph_n = 2'd0;
      endcase
      m_en[k] = en_n;
      m_ph[k] = ph_n;
    end
    m_ill = |(rt & rf);
  endtask

  task automatic compare_all();
    string en_tag [3];
    en_tag[0] = "R4 early enable";
    en_tag[1] = "R3 basic enable";
    en_tag[2] = "R9 slow-pair enable";
    for (int k = 0; k < 3; k++) begin
      chk(en_tag[k], {3'b0, en_o[k]}, {3'b0, m_en[k]});
      chk("R5 phase", {2'b0, ph_o[k]}, {2'b0, m_ph[k]});
      chk("R6 ack_up", {3'b0, ack_o[k]}, {3'b0, (m_ph[k] >= 2'd2)});
      chk("R8 illegal", {3'b0, ill_o[k]}, {3'b0, m_ill});
    end
  endtask

  // drive at falling edge, model after rising edge, compare at next falling edge
  task automatic step(input logic [N-1:0] t, input logic [N-1:0] f, input logic a);
    rt = t; rf = f; ack = a;
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R1 reset pwr_en", {3'b0, en_o[k]}, 4'd0);
      chk("R1 reset ack_up", {3'b0, ack_o[k]}, 4'd0);
      chk("R1 reset phase", {2'b0, ph_o[k]}, 4'd0);
      chk("R1 reset illegal", {3'b0, ill_o[k]}, 4'd0);
    end
    rst_n = 1'b1;

    // R10: partial token from wait
    repeat (3) step(4'b0001, 4'b0000, 1'b0);
    chk("R10 partial no enable", {3'b0, en_o[0]}, 4'd0);
    chk("R10 partial stays wait", {2'b0, ph_o[0]}, 4'd0);

    // R2: full token enables
    step(4'b0101, 4'b1010, 1'b0);
    chk("R2 full token enables", {3'b0, en_o[0]}, 4'd1);
    chk("R2 full token enables basic", {3'b0, en_o[1]}, 4'd1);
    step(4'b0101, 4'b1010, 1'b0);
    chk("R5 evaluate", {2'b0, ph_o[0]}, 4'd1);
    step(4'b0101, 4'b1010, 1'b0);
    chk("R5 hold", {2'b0, ph_o[0]}, 4'd2);
    chk("R6 ack_up in hold", {3'b0, ack_o[0]}, 4'd1);

    // R4 vs R3: ack with token still present
    step(4'b0101, 4'b1010, 1'b1);
    chk("R4 early drop", {3'b0, en_o[0]}, 4'd0);
    chk("R3 basic holds", {3'b0, en_o[1]}, 4'd1);

    // R10: partial in hold
    step(4'b0001, 4'b0000, 1'b0);
    chk("R10 partial keeps hold", {2'b0, ph_o[0]}, 4'd2);

    // R7: empty then return to wait
    step(4'b0000, 4'b0000, 1'b1);
    chk("R7 hold to discharge", {2'b0, ph_o[0]}, 4'd3);
    chk("R3 basic clears", {3'b0, en_o[1]}, 4'd0);
    step(4'b0000, 4'b0000, 1'b1);
    chk("R7 discharge to wait", {2'b0, ph_o[0]}, 4'd0);
    chk("R7 ack_up released", {3'b0, ack_o[0]}, 4'd0);

    // R8: illegal pair
    step(4'b1000, 4'b1000, 1'b0);
    chk("R8 illegal raised", {3'b0, ill_o[0]}, 4'd1);
    step(4'b0000, 4'b0000, 1'b0);
    chk("R8 illegal cleared", {3'b0, ill_o[0]}, 4'd0);

    // R9: only the slow pair live
    step(4'b0100, 4'b0000, 1'b0);
    chk("R9 slow pair enables", {3'b0, en_o[2]}, 4'd1);
    chk("R9 full detector ignores", {3'b0, en_o[0]}, 4'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] t, f;
      int kind;
      kind = $urandom % 16;
      t = N'($urandom);
      if (kind < 7)       f = ~t;
      else if (kind < 13) begin t = '0; f = '0; end
      else if (kind < 15) f = '0;
      else                f = t | N'(1);
      step(t, f, ($urandom % 3) == 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule